// File: doc/BRIEF.md
# Single-Source Edge Interrupt Request Path

This block carries one external event to a processor core as an interrupt. A rising edge on the input pin is brought into the clock domain through a flip-flop synchronizer. When the source is armed, that edge sets a sticky pending flag. The flag only becomes an interrupt request while the source is enabled and the processor's global mask bit is clear. The request comes from a register.

When the core takes the interrupt, it pulses an acknowledge. The block then sets the mask, so the same pending source cannot break into its own handler, and keeps the previous mask value in a one-entry save register. A return strobe puts the saved value back. A fixed 16-bit handler address is always presented on the vector output.

Software can read the flag, clear it with a write-one strobe, and write the mask bit directly. Writing the mask allows nested acceptance. A source that is armed but not enabled works as a polled status bit.

Top module: `irq_edge_path`

## Requirements
- R1: A 0-to-1 change on `pin_in`, held for at least three clocks while the source is armed, sets `stat_flag` at the third rising clock edge after the change. There are two synchronizer stages and one edge-detect stage.
- R2: An edge that arrives while `stat_arm` is 0 is never recorded. Arming the source later, with the pin still high, leaves `stat_flag` at 0.
- R3: A cycle with `flag_clr` = 1 clears `stat_flag` at the next edge. If an armed edge is detected in that same cycle, the flag stays at 1.
- R4: `irq_req` is a register that loads (flag AND enable AND NOT mask AND NOT acknowledge). While the enable is 0, a recorded flag is kept and no request is raised. Once the enable is written to 1, the request rises two edges after the write cycle.
- R5: A cycle with `irq_ack` = 1 sets `stat_mask` to 1 at the next edge, keeps the previous mask value as the saved value, and leaves `irq_req` at 0 after that edge.
- R6: A cycle with `irq_rti` = 1 restores `stat_mask` to the saved value. If the flag has not been cleared, `irq_req` rises again one edge later, and this repeats for every acknowledge and return.
- R7: A cycle with `mask_we` = 1 loads `mask_d` into `stat_mask`. When several mask actions fall in the same cycle, acknowledge wins over return, and return wins over the write.
- R8: `irq_vector` always equals 16'hFFEE.
- R9: With the source armed and the enable at 0, `stat_flag` reports armed edges and `irq_req` stays at 0.
- R10: While `rst` is 1, `stat_flag`, `stat_arm`, `stat_en` and `irq_req` become 0 and `stat_mask` becomes 1. `ctl_we` = 1 loads `ctl_arm` and `ctl_en` into `stat_arm` and `stat_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous event pin |
| ctl_we | input | 1 | Write strobe for arm and enable |
| ctl_arm | input | 1 | Arm value to write |
| ctl_en | input | 1 | Enable value to write |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| mask_we | input | 1 | Direct mask write strobe |
| mask_d | input | 1 | Mask value to write |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_rti | input | 1 | Core returns from the handler |
| irq_req | output | 1 | Registered interrupt request |
| irq_vector | output | 16 | Handler address |
| stat_flag | output | 1 | Pending flag |
| stat_mask | output | 1 | Global mask bit |
| stat_arm | output | 1 | Arm state |
| stat_en | output | 1 | Enable state |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a flag clear and a detected armed edge: the bench raises the pin two cycles ahead so that the detected edge lines up with the clear strobe, and it expects the flag to stay set. The second pair is the mask actions. Acknowledge, return and direct write are driven together, and the resulting mask must follow the acknowledge-first, then-return order. A long randomized run then drives all the strobes together against a cycle-level reference model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W = 16;
  localparam logic [VEC_W-1:0] DEF_VECTOR = 16'hFFEE;

  typedef enum logic [1:0] {
    MOP_HOLD = 2'd0,
    MOP_ACK  = 2'd1,
    MOP_RTI  = 2'd2,
    MOP_WR   = 2'd3
  } mask_op_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= pin;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic arm,
  input  logic clr,
  output logic flag
);
  logic set_evt;

  assign set_evt = rise & arm;

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ack,
  input  logic rti,
  input  logic wr,
  input  logic wr_d,
  output logic mask,
  output logic saved
);
  mask_op_e op;

  always_comb begin
    if (ack)      op = MOP_ACK;
    else if (rti) op = MOP_RTI;
    else if (wr)  op = MOP_WR;
    else          op = MOP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= 1'b1;
      saved <= 1'b1;
    end else begin
      case (op)
        MOP_ACK: begin
          saved <= mask;
          mask  <= 1'b1;
        end
        MOP_RTI: mask <= saved;
        MOP_WR:  mask <= wr_d;
        default: mask <= mask;
      endcase
    end
  end
endmodule

// File: rtl/irq_edge_path.sv
module irq_edge_path
  import irq_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] VECTOR      = DEF_VECTOR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic             ctl_we,
  input  logic             ctl_arm,
  input  logic             ctl_en,
  input  logic             flag_clr,
  input  logic             mask_we,
  input  logic             mask_d,
  input  logic             irq_ack,
  input  logic             irq_rti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector,
  output logic             stat_flag,
  output logic             stat_mask,
  output logic             stat_arm,
  output logic             stat_en
);
  logic rise_w;
  logic flag_w;
  logic mask_w;
  logic saved_w;
  logic arm_q;
  logic en_q;
  logic req_q;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin (pin_in),
    .rise(rise_w)
  );

  irq_flag u_flag (
    .clk (clk),
    .rst (rst),
    .rise(rise_w),
    .arm (arm_q),
    .clr (flag_clr),
    .flag(flag_w)
  );

  irq_mask_ctl u_mask (
    .clk  (clk),
    .rst  (rst),
    .ack  (irq_ack),
    .rti  (irq_rti),
    .wr   (mask_we),
    .wr_d (mask_d),
    .mask (mask_w),
    .saved(saved_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (ctl_we) begin
      arm_q <= ctl_arm;
      en_q  <= ctl_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= flag_w & en_q & ~mask_w & ~irq_ack;
  end

  assign irq_req    = req_q;
  assign irq_vector = VECTOR;
  assign stat_flag  = flag_w;
  assign stat_mask  = mask_w;
  assign stat_arm   = arm_q;
  assign stat_en    = en_q;
endmodule

// File: rtl/irq_edge_path_chk.sv
module irq_edge_path_chk (
  input logic clk,
  input logic rst,
  input logic rise,
  input logic arm,
  input logic en,
  input logic flag,
  input logic mask,
  input logic saved,
  input logic req,
  input logic ack,
  input logic rti,
  input logic clr
);
  a_r1_armed_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (rise && arm) |=> flag);

  a_r2_rise_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(arm));

  a_r3_clear_works: assert property (@(posedge clk) disable iff (rst)
    (clr && !(rise && arm)) |=> !flag);

  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !req);

  a_r5_ack_masks: assert property (@(posedge clk) disable iff (rst)
    ack |=> (mask && !req));

  a_r5_ack_saves: assert property (@(posedge clk) disable iff (rst)
    ack |=> (saved == $past(mask)));

  a_r6_rti_restores: assert property (@(posedge clk) disable iff (rst)
    (rti && !ack) |=> (mask == $past(saved)));
endmodule

bind irq_edge_path irq_edge_path_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .rise (rise_w),
  .arm  (arm_q),
  .en   (en_q),
  .flag (flag_w),
  .mask (mask_w),
  .saved(saved_w),
  .req  (req_q),
  .ack  (irq_ack),
  .rti  (irq_rti),
  .clr  (flag_clr)
);

// File: tb/tb_irq_edge_path.sv
module tb_irq_edge_path;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rst, pin_in, ctl_we, ctl_arm, ctl_en, flag_clr, mask_we, mask_d, irq_ack, irq_rti;
  logic irq_req, stat_flag, stat_mask, stat_arm, stat_en;
  logic [15:0] irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic m_s1, m_s2, m_pv, m_flag, m_arm, m_en, m_mask, m_sav, m_req;

  always #(CLK_NS/2) clk = ~clk;

  irq_edge_path dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .ctl_we(ctl_we), .ctl_arm(ctl_arm),
    .ctl_en(ctl_en), .flag_clr(flag_clr), .mask_we(mask_we), .mask_d(mask_d),
    .irq_ack(irq_ack), .irq_rti(irq_rti), .irq_req(irq_req), .irq_vector(irq_vector),
    .stat_flag(stat_flag), .stat_mask(stat_mask), .stat_arm(stat_arm), .stat_en(stat_en)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic idle();
    ctl_we = 0; flag_clr = 0; mask_we = 0; irq_ack = 0; irq_rti = 0;
  endtask

  task automatic wr_ctl(input logic a, input logic e);
    ctl_we = 1; ctl_arm = a; ctl_en = e; cyc(); ctl_we = 0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1; cyc(); irq_ack = 0;
  endtask

  task automatic pulse_rti();
    irq_rti = 1; cyc(); irq_rti = 0;
  endtask

  // one clock of the reference model, evaluated from the inputs held in the cycle
  task automatic model_step();
    logic e, nf, nr, nm, ns;
    e  = m_s2 & ~m_pv;
    nf = (e & m_arm) ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    nr = m_flag & m_en & ~m_mask & ~irq_ack;
    nm = m_mask; ns = m_sav;
    if (irq_ack)      begin ns = m_mask; nm = 1'b1; end
    else if (irq_rti) nm = m_sav;
    else if (mask_we) nm = mask_d;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_pv = 0; m_flag = 0; m_arm = 0; m_en = 0;
      m_mask = 1; m_sav = 1; m_req = 0;
    end else begin
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      m_flag = nf; m_req = nr; m_mask = nm; m_sav = ns;
      if (ctl_we) begin m_arm = ctl_arm; m_en = ctl_en; end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; pin_in = 0; ctl_arm = 0; ctl_en = 0; mask_d = 0; idle();
    cyc(3);
    rst = 0;
    chk("R10 flag", stat_flag, 0);
    chk("R10 req", irq_req, 0);
    chk("R10 mask", stat_mask, 1);
    chk("R10 arm/en", {stat_arm, stat_en}, 2'b00);
    chk("R8 vector", irq_vector, 16'hFFEE);

    // R2: disarmed edge is lost
    pin_in = 1; cyc(4);
    chk("R2 disarmed edge", stat_flag, 0);
    wr_ctl(1, 0);
    chk("R10 arm write", {stat_arm, stat_en}, 2'b10);
    cyc(3);
    chk("R2 late arm", stat_flag, 0);
    pin_in = 0; cyc(3);

    // R1 timing and R9 polled mode
    pin_in = 1; cyc(2);
    chk("R1 not yet", stat_flag, 0);
    cyc();
    chk("R1 flag set", stat_flag, 1);
    cyc(3);
    chk("R9 polled no req", irq_req, 0);
    pin_in = 0;

    // R7 mask write, R4 deferred delivery
    mask_we = 1; mask_d = 0; cyc(); mask_we = 0;
    chk("R7 mask write", stat_mask, 0);
    cyc(2);
    chk("R4 held flag", stat_flag, 1);
    chk("R4 disabled no req", irq_req, 0);
    wr_ctl(1, 1);
    chk("R4 one edge after write", irq_req, 0);
    cyc();
    chk("R4 req raised", irq_req, 1);

    // R5 acknowledge, R6 repeated re-entry
    pulse_ack();
    chk("R5 mask set", stat_mask, 1);
    chk("R5 req dropped", irq_req, 0);
    for (int k = 0; k < 2; k++) begin
      pulse_rti();
      chk("R6 mask restored", stat_mask, 0);
      cyc();
      chk("R6 re-entry", irq_req, 1);
      pulse_ack();
      chk("R5 re-ack", irq_req, 0);
    end

    // R7 nested acceptance by unmasking inside the handler
    mask_we = 1; mask_d = 0; cyc(); mask_we = 0;
    chk("R7 unmask in handler", stat_mask, 0);
    cyc();
    chk("R7 nested req", irq_req, 1);
    pulse_ack();
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R3 clear", stat_flag, 0);
    pulse_rti();
    cyc(2);
    chk("R6 cleared no re-entry", irq_req, 0);

    // R3 clear in the same cycle as a detected armed edge
    pin_in = 1; cyc(3); pin_in = 0; cyc(3);
    chk("R1 flag before collision", stat_flag, 1);
    pin_in = 1; cyc(2);
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R3 edge wins", stat_flag, 1);
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R3 clear after", stat_flag, 0);
    pin_in = 0;

    // R7 priority: ack > rti > write
    irq_ack = 1; irq_rti = 1; mask_we = 1; mask_d = 0; cyc(); idle();
    chk("R7 ack beats rti/write", stat_mask, 1);
    irq_rti = 1; mask_we = 1; mask_d = 1; cyc(); idle();
    chk("R7 rti beats write", stat_mask, 0);

    // randomized run against the reference model
    rst = 1; model_step(); cyc(); model_step(); cyc(); rst = 0;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) pin_in = ~pin_in;
      ctl_we   = ($urandom_range(0, 15) == 0);
      ctl_arm  = ($urandom_range(0, 3) != 0);
      ctl_en   = ($urandom_range(0, 2) != 0);
      flag_clr = ($urandom_range(0, 7) == 0);
      mask_we  = ($urandom_range(0, 19) == 0);
      mask_d   = $urandom_range(0, 1);
      irq_ack  = irq_req ? ($urandom_range(0, 1) == 1) : ($urandom_range(0, 31) == 0);
      irq_rti  = ($urandom_range(0, 9) == 0);
      model_step();
      cyc();
      chk("R1/R2/R3 flag", stat_flag, m_flag);
      chk("R4/R9 req", irq_req, m_req);
      chk("R5/R6/R7 mask", stat_mask, m_mask);
      chk("R10 arm/en", {stat_arm, stat_en}, {m_arm, m_en});
    end
    idle();
    chk("R8 vector end", irq_vector, 16'hFFEE);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule